// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block chooses where each of the two execute-stage ALU operands comes from in a five-stage pipeline. An operand can be the value read from the register file and held with the instruction, the result sitting in the register after the execute stage, or the value about to be written back. Each source register number of the executing instruction is compared with the destination numbers of the two older instructions ahead of it. A result is used as soon as it exists, so the consumer does not wait for write-back.

The block also contains the architectural register file with a same-cycle write-to-read bypass. When the write-back stage writes a register in the cycle that the decode stage reads it, the decode read returns the new value. The write-back port of the forwarding logic and the register file's write port are the same pins. An instruction three or more places behind its producer therefore reads a correct value in decode, and it needs no ALU forwarding.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage qualifies for an operand, its select is 2'b00 and the operand equals the value carried with the instruction (`ex_rs_val` / `ex_rt_val`). The select is never 2'b11.
- R2: When the memory-stage write enable is 1, its destination is nonzero and it equals the operand's source register, the select is 2'b10 and the operand equals `mem_result`.
- R3: When only the write-back stage qualifies (write enable 1, destination nonzero and equal to the source register), the select is 2'b01 and the operand equals `wb_data`.
- R4: When both stages qualify for the same operand, the memory stage wins: the select is 2'b10 and the operand is `mem_result`.
- R5: A source or destination register number of 0 never causes forwarding.
- R6: A stage whose write enable is 0 never forwards, even when its destination matches.
- R7: The two operands are resolved independently. When both name the same register, both receive the same forwarded value.
- R8: After reset every register reads as zero. Afterwards a decode read returns the data of the last write to that register.
- R9: A decode read of a nonzero register that the write-back port writes in the same cycle returns the data being written.
- R10: Register 0 always reads as zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register file |
| rst_n | input | 1 | Active-low synchronous reset, clears the register file |
| id_rs_addr | input | 5 | Decode-stage first read register |
| id_rt_addr | input | 5 | Decode-stage second read register |
| id_rs_data | output | 32 | Decode-stage first read value, with bypass |
| id_rt_data | output | 32 | Decode-stage second read value, with bypass |
| ex_rs | input | 5 | First source register of the executing instruction |
| ex_rt | input | 5 | Second source register of the executing instruction |
| ex_rs_val | input | 32 | First operand value carried from decode |
| ex_rt_val | input | 32 | Second operand value carried from decode |
| mem_rd | input | 5 | Destination of the instruction in the memory stage |
| mem_we | input | 1 | Register write enable of the memory-stage instruction |
| mem_result | input | 32 | Result held after the execute stage |
| wb_rd | input | 5 | Destination of the write-back instruction, also the register file write address |
| wb_we | input | 1 | Write-back write enable, also the register file write enable |
| wb_data | input | 32 | Write-back value, also the register file write data |
| sel_a | output | 2 | First operand select: 00 register file, 10 memory stage, 01 write-back |
| sel_b | output | 2 | Second operand select, same encoding |
| opnd_a | output | 32 | First ALU operand after forwarding |
| opnd_b | output | 32 | Second ALU operand after forwarding |

## Verification
The hardest case to reach is both later stages writing the register that one operand reads, with both enables set and the register nonzero. With uniform 5-bit register numbers this happens in only a few cycles per thousand. The random stimulus therefore draws register numbers from a small pool that includes zero, which makes double matches, register-0 matches and disabled-enable matches common. Directed cycles add the exact priority, zero-register, same-register-on-both-operands and same-cycle bypass cases on top.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int NUM_OP = 2;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } sel_e;
endpackage

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
    parameter int REG_W  = fwd_pkg::REG_W,
    parameter int DATA_W = fwd_pkg::DATA_W,
    parameter int NRD    = fwd_pkg::NUM_OP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_W-1:0]  raddr [NRD],
    output logic [DATA_W-1:0] rdata [NRD]
);
    localparam int NREG = 2 ** REG_W;

    logic [DATA_W-1:0] regs_q [NREG];
    logic [DATA_W-1:0] regs_d [NREG];
    logic              wr_ok;

    assign wr_ok = we && (waddr != '0);

    always_comb begin
        regs_d = regs_q;
        if (wr_ok) begin
            regs_d[waddr] = wdata;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (wr_ok && (waddr == raddr[p])) begin
                rdata[p] = wdata;
            end else begin
                rdata[p] = regs_q[raddr[p]];
            end
        end
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick #(
    parameter int REG_W = fwd_pkg::REG_W
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    output fwd_pkg::sel_e    sel
);
    logic mem_hit;
    logic wb_hit;

    assign mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
    assign wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);

    always_comb begin
        if (mem_hit) begin
            sel = fwd_pkg::SEL_MEM;
        end else if (wb_hit) begin
            sel = fwd_pkg::SEL_WB;
        end else begin
            sel = fwd_pkg::SEL_RF;
        end
    end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux #(
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input  fwd_pkg::sel_e     sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd
);
    always_comb begin
        unique case (sel)
            fwd_pkg::SEL_MEM: opnd = mem_val;
            fwd_pkg::SEL_WB:  opnd = wb_val;
            default:          opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
    parameter int REG_W  = fwd_pkg::REG_W,
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  id_rs_addr,
    input  logic [REG_W-1:0]  id_rt_addr,
    output logic [DATA_W-1:0] id_rs_data,
    output logic [DATA_W-1:0] id_rt_data,
    input  logic [REG_W-1:0]  ex_rs,
    input  logic [REG_W-1:0]  ex_rt,
    input  logic [DATA_W-1:0] ex_rs_val,
    input  logic [DATA_W-1:0] ex_rt_val,
    input  logic [REG_W-1:0]  mem_rd,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_result,
    input  logic [REG_W-1:0]  wb_rd,
    input  logic              wb_we,
    input  logic [DATA_W-1:0] wb_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NOP = fwd_pkg::NUM_OP;

    logic [REG_W-1:0]  rd_addr [NOP];
    logic [DATA_W-1:0] rd_data [NOP];
    logic [REG_W-1:0]  src     [NOP];
    logic [DATA_W-1:0] rf_val  [NOP];
    logic [DATA_W-1:0] op_val  [NOP];
    fwd_pkg::sel_e     sel     [NOP];

    assign rd_addr[0] = id_rs_addr;
    assign rd_addr[1] = id_rt_addr;
    assign id_rs_data = rd_data[0];
    assign id_rt_data = rd_data[1];

    fwd_regfile #(.REG_W(REG_W), .DATA_W(DATA_W), .NRD(NOP)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_we),
        .waddr (wb_rd),
        .wdata (wb_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign src[0]    = ex_rs;
    assign src[1]    = ex_rt;
    assign rf_val[0] = ex_rs_val;
    assign rf_val[1] = ex_rt_val;

    for (genvar g = 0; g < NOP; g++) begin : g_op
        fwd_pick #(.REG_W(REG_W)) pick_i (
            .src    (src[g]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (sel[g])
        );
        fwd_opmux #(.DATA_W(DATA_W)) mux_i (
            .sel     (sel[g]),
            .rf_val  (rf_val[g]),
            .mem_val (mem_result),
            .wb_val  (wb_data),
            .opnd    (op_val[g])
        );
    end

    assign sel_a  = sel[0];
    assign sel_b  = sel[1];
    assign opnd_a = op_val[0];
    assign opnd_b = op_val[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_W  = fwd_pkg::REG_W,
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  id_rs_addr,
    input logic [DATA_W-1:0] id_rs_data,
    input logic [REG_W-1:0]  ex_rs,
    input logic [REG_W-1:0]  ex_rt,
    input logic [REG_W-1:0]  mem_rd,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_result,
    input logic [REG_W-1:0]  wb_rd,
    input logic              wb_we,
    input logic [DATA_W-1:0] wb_data,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a
);
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'b11) && (sel_b != 2'b11)); // R1
    AST_MEM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mem_rd != '0) && (mem_rd == ex_rs)) |-> (sel_a == 2'b10)); // R4
    AST_MEM_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'b10) |-> (opnd_a == mem_result)); // R2
    AST_WB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mem_we && (mem_rd == ex_rt) && (mem_rd != '0)) && wb_we && (wb_rd != '0) && (wb_rd == ex_rt))
        |-> (sel_b == 2'b01)); // R3
    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs == '0) |-> (sel_a == 2'b00)); // R5
    AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we && !wb_we) |-> ((sel_a == 2'b00) && (sel_b == 2'b00))); // R6
    AST_SAME_CYCLE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && (wb_rd != '0) && (wb_rd == id_rs_addr)) |-> (id_rs_data == wb_data)); // R9
    AST_REG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs_addr == '0) |-> (id_rs_data == '0)); // R10
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_rs_addr (id_rs_addr),
    .id_rs_data (id_rs_data),
    .ex_rs      (ex_rs),
    .ex_rt      (ex_rt),
    .mem_rd     (mem_rd),
    .mem_we     (mem_we),
    .mem_result (mem_result),
    .wb_rd      (wb_rd),
    .wb_we      (wb_we),
    .wb_data    (wb_data),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .opnd_a     (opnd_a)
);

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  id_rs_addr = '0, id_rt_addr = '0;
    logic [31:0] id_rs_data, id_rt_data;
    logic [4:0]  ex_rs = '0, ex_rt = '0, mem_rd = '0, wb_rd = '0;
    logic [31:0] ex_rs_val = '0, ex_rt_val = '0, mem_result = '0, wb_data = '0;
    logic        mem_we = 1'b0, wb_we = 1'b0;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] model [32];

    always #4 clk = ~clk;

    fwd_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .id_rs_addr(id_rs_addr), .id_rt_addr(id_rt_addr),
        .id_rs_data(id_rs_data), .id_rt_data(id_rt_data),
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_result(mem_result),
        .wb_rd(wb_rd), .wb_we(wb_we), .wb_data(wb_data),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    function automatic logic [1:0] exp_sel(logic [4:0] s);
        if (mem_we && mem_rd != 0 && mem_rd == s) return 2'b10;
        if (wb_we && wb_rd != 0 && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(logic [4:0] s);
        logic m = mem_we && mem_rd != 0 && mem_rd == s;
        logic w = wb_we && wb_rd != 0 && wb_rd == s;
        if (s == 0) return "R5";
        if (m && w) return "R4";
        if (m) return "R2";
        if (w) return "R3";
        if ((mem_rd == s) || (wb_rd == s)) return "R6";
        return "R1";
    endfunction

    function automatic logic [31:0] exp_rd(logic [4:0] a);
        if (a == 0) return 32'h0;
        if (wb_we && wb_rd == a) return wb_data;
        return model[a];
    endfunction

    function automatic string rd_tag(logic [4:0] a);
        if (a == 0) return "R10";
        if (wb_we && wb_rd == a) return "R9";
        return "R8";
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // inputs are already driven; check near the falling edge, then let the write land
    task automatic cycle();
        logic [1:0] ea, eb;
        #3;
        ea = exp_sel(ex_rs);
        eb = exp_sel(ex_rt);
        chk(sel_tag(ex_rs), "sel_a", {30'h0, sel_a}, {30'h0, ea});
        chk(sel_tag(ex_rt), "sel_b", {30'h0, sel_b}, {30'h0, eb});
        chk(sel_tag(ex_rs), "opnd_a", opnd_a,
            ea == 2'b10 ? mem_result : ea == 2'b01 ? wb_data : ex_rs_val);
        chk(sel_tag(ex_rt), "opnd_b", opnd_b,
            eb == 2'b10 ? mem_result : eb == 2'b01 ? wb_data : ex_rt_val);
        chk(rd_tag(id_rs_addr), "id_rs_data", id_rs_data, exp_rd(id_rs_addr));
        chk(rd_tag(id_rt_addr), "id_rt_data", id_rt_data, exp_rd(id_rt_addr));
        @(posedge clk);
        if (rst_n && wb_we && wb_rd != 0) model[wb_rd] = wb_data;
        #1;
    endtask

    task automatic drive(logic [4:0] rs, logic [4:0] rt, logic [4:0] mrd, logic mwe,
                         logic [4:0] wrd, logic wwe);
        ex_rs = rs; ex_rt = rt; mem_rd = mrd; mem_we = mwe; wb_rd = wrd; wb_we = wwe;
        ex_rs_val = $urandom; ex_rt_val = $urandom;
        mem_result = $urandom; wb_data = $urandom;
    endtask

    initial begin
        void'($urandom(32'd2718));
        foreach (model[i]) model[i] = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R8: registers read zero after reset
        for (int i = 0; i < 32; i += 2) begin
            drive(0, 0, 0, 0, 0, 0);
            id_rs_addr = i[4:0]; id_rt_addr = i[4:0] + 5'd1;
            cycle();
        end
        // R4: both stages match the first operand
        drive(5'd7, 5'd3, 5'd7, 1, 5'd7, 1); id_rs_addr = 5'd7; cycle();
        // R5: destination zero matches a zero source
        drive(5'd0, 5'd0, 5'd0, 1, 5'd0, 1); id_rs_addr = 5'd0; cycle();
        // R6: matches with enables low
        drive(5'd9, 5'd9, 5'd9, 0, 5'd9, 0); cycle();
        // R7: both operands name the same forwarded register
        drive(5'd12, 5'd12, 5'd12, 1, 5'd4, 1); cycle();
        drive(5'd13, 5'd13, 5'd1, 1, 5'd13, 1); cycle();
        // R9 then R8: bypass write, then read back next cycle
        drive(5'd1, 5'd2, 5'd0, 0, 5'd20, 1); id_rs_addr = 5'd20; id_rt_addr = 5'd20; cycle();
        drive(5'd1, 5'd2, 5'd0, 0, 5'd21, 0); cycle();
        // R10: write to register 0 ignored
        drive(5'd1, 5'd2, 5'd0, 0, 5'd0, 1); wb_data = 32'hDEADBEEF; id_rs_addr = 0; cycle();
        drive(5'd1, 5'd2, 5'd0, 0, 5'd0, 0); id_rs_addr = 0; cycle();
        // random: small register pool raises match rates
        for (int n = 0; n < 3000; n++) begin
            drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1));
            id_rs_addr = (n % 4 == 0) ? 5'($urandom) : 5'($urandom_range(0, 3));
            id_rt_addr = 5'($urandom_range(0, 3));
            cycle();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule